// File: doc/BRIEF.md
# Encoder Event Timestamp Capture

This block keeps a free-running 16-bit time base that advances once per microsecond. The microsecond tick is a clock enable made by dividing the system clock by a parameter. Each of four encoder axes has a one-cycle count strobe. When an axis strobes, the block stores the present time base value as that axis's time of last count.

A snapshot strobe copies all four per-axis stamps and the raw time base into a set of holding registers in a single clock edge. Software reading the holding registers can subtract each axis stamp from the captured time base. The result is the time since that axis last moved, which is useful for estimating velocity at low speeds.

The held values are presented both as full 16-bit words and through a byte-wide read port. On that port, the low byte of each word sits at the even select value and the high byte at the next odd value. Producing the count strobes and decoding the host bus are done elsewhere.

Top module: `evt_stamp_capture`

## Requirements
- R1: The time base advances by exactly one every DIV clock cycles, so any window of k*DIV cycles adds exactly k.
- R2: The time base wraps from 0xFFFF to 0x0000 and continues counting, with no flag or stall.
- R3: A count strobe on axis i stores the time base value that held before that clock edge into axis i's live stamp. The live stamps of the other axes are left unchanged.
- R4: A snapshot strobe copies all four live stamps and the time base into the holding registers on the same clock edge.
- R5: Between snapshots the held outputs `stamp_q`, `base_q` and `rd_byte` (for a fixed select) do not change, even while count strobes arrive.
- R6: When a count strobe and a snapshot strobe fall in the same cycle, the snapshot takes that axis's stamp from before the update. The new stamp appears at the following snapshot.
- R7: The byte port `rd_byte` maps `rd_sel` as follows:
  - Select 2k gives the low byte of held axis k, and select 2k+1 gives its high byte, for k from 0 to 3.
  - Select 8 gives the low byte of the held time base, and select 9 gives its high byte.
  - Selects 10 to 15 give 0x00.
- R8: After reset, the time base, all live stamps and all held values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_evt | input | NAXES | One-cycle count strobe per axis |
| snap_req | input | 1 | Snapshot strobe |
| rd_sel | input | SELW | Byte select for the read port |
| stamp_q | output | NAXES*16 | Held axis stamps, axis k in bits [16k+15:16k] |
| base_q | output | 16 | Held time base |
| rd_byte | output | 8 | Selected byte of the held values |

## Verification
On every cycle, the assertions check the following:
- the divider never fires on two cycles in a row;
- the time base moves by exactly +1 on a tick and holds otherwise;
- a live stamp holds when its axis is quiet;
- the held values hold when no snapshot is requested.

Only the bench scenarios can show the remaining behaviour. That covers which time base value a stamp receives, the old-value rule when a strobe and a snapshot coincide, the exact rate over long windows, the wrap at 0xFFFF, and the byte map of the read port.

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture #(
  parameter int DIV   = 200,
  parameter int NAXES = 4,
  localparam int TW   = 16,
  localparam int SELW = $clog2(2*NAXES+2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NAXES-1:0]      cnt_evt,
  input  logic                  snap_req,
  input  logic [SELW-1:0]       rd_sel,
  output logic [NAXES*TW-1:0]   stamp_q,
  output logic [TW-1:0]         base_q,
  output logic [7:0]            rd_byte
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre;
  logic [TW-1:0] tbase;
  logic [TW-1:0] live [NAXES];
  logic [TW-1:0] held [NAXES];
  logic          tick;

  assign tick = (pre == PW'(DIV-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      tbase <= '0;
    end else begin
      pre   <= tick ? '0 : pre + 1'b1;
      if (tick) tbase <= tbase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (snap_req) base_q <= tbase;
  end

  generate
    for (genvar i = 0; i < NAXES; i++) begin : g_axis
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          live[i] <= '0;
          held[i] <= '0;
        end else begin
          if (cnt_evt[i]) live[i] <= tbase;
          if (snap_req)   held[i] <= live[i];
        end
      end
      assign stamp_q[i*TW +: TW] = held[i];

      assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_evt[i] |=> $stable(live[i]));
      assert_held_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(held[i]));
    end
  endgenerate

  always_comb begin
    rd_byte = 8'h00;
    for (int k = 0; k < NAXES; k++) begin
      if (rd_sel == SELW'(2*k))   rd_byte = held[k][7:0];
      if (rd_sel == SELW'(2*k+1)) rd_byte = held[k][15:8];
    end
    if (rd_sel == SELW'(2*NAXES))   rd_byte = base_q[7:0];
    if (rd_sel == SELW'(2*NAXES+1)) rd_byte = base_q[15:8];
  end

  generate
    if (DIV > 1) begin : g_spacing
      assert_tick_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

  assert_base_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tbase == $past(tbase) + 16'd1);
  assert_base_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tbase));
  assert_base_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(base_q));
endmodule

// File: tb/sim_evt_stamp_capture.sv
module sim_evt_stamp_capture;
  localparam int DIV = 2;
  localparam int NA  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NA-1:0] cnt_evt = '0;
  logic          snap_req = 1'b0;
  logic [3:0]    rd_sel = '0;
  logic [NA*16-1:0] stamp_q;
  logic [15:0]   base_q;
  logic [7:0]    rd_byte;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_held [NA];

  always #2.5 clk = ~clk;

  evt_stamp_capture #(.DIV(DIV), .NAXES(NA)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_evt(cnt_evt), .snap_req(snap_req),
    .rd_sel(rd_sel), .stamp_q(stamp_q), .base_q(base_q), .rd_byte(rd_byte));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_snap(input logic [NA-1:0] ev);
    @(negedge clk); snap_req = 1'b1; cnt_evt = ev;
    @(negedge clk); snap_req = 1'b0; cnt_evt = '0;
  endtask

  task automatic t_reset_R8;
    chk("R8 base", base_q, 0);
    for (int i = 0; i < NA; i++) chk("R8 stamp", stamp_q[i*16 +: 16], 0);
    chk("R8 byte", rd_byte, 0);
  endtask

  task automatic t_rate_R1(input int k);
    logic [15:0] b1;
    pulse_snap('0); b1 = base_q;
    repeat (2*k - 2) @(negedge clk);
    pulse_snap('0);
    chk("R1 rate", base_q - b1, k);
  endtask

  task automatic t_axis_R3_R6(input int a);
    logic [15:0] b;
    logic [NA-1:0] ev;
    ev = '0; ev[a] = 1'b1;
    pulse_snap(ev);
    b = base_q;
    for (int i = 0; i < NA; i++) chk("R6 old stamp kept", stamp_q[i*16 +: 16], exp_held[i]);
    exp_held[a] = b;
    pulse_snap('0);
    for (int i = 0; i < NA; i++) chk("R3 stamp value", stamp_q[i*16 +: 16], exp_held[i]);
  endtask

  task automatic t_all_R4;
    logic [15:0] b;
    pulse_snap('1);
    b = base_q;
    pulse_snap('0);
    for (int i = 0; i < NA; i++) begin
      exp_held[i] = b;
      chk("R4 joint capture", stamp_q[i*16 +: 16], b);
    end
  endtask

  task automatic t_hold_R5;
    logic [63:0] s0;
    logic [15:0] b0;
    logic [7:0] r0;
    rd_sel = 4'd8;
    @(negedge clk);
    s0 = stamp_q; b0 = base_q; r0 = rd_byte;
    for (int j = 0; j < 20; j++) begin
      cnt_evt = 4'(j);
      @(negedge clk);
    end
    cnt_evt = '0;
    repeat (5) @(negedge clk);
    chk("R5 stamps held", {32'd0, stamp_q[31:0]} == {32'd0, s0[31:0]} && stamp_q[63:32] == s0[63:32], 1);
    chk("R5 base held", base_q, b0);
    chk("R5 byte held", rd_byte, r0);
  endtask

  task automatic t_bytes_R7;
    logic [7:0] e;
    for (int s = 0; s < 16; s++) begin
      rd_sel = 4'(s);
      #1;
      if (s < 2*NA) e = s[0] ? stamp_q[(s/2)*16+8 +: 8] : stamp_q[(s/2)*16 +: 8];
      else if (s == 2*NA) e = base_q[7:0];
      else if (s == 2*NA+1) e = base_q[15:8];
      else e = 8'h00;
      chk("R7 byte map", rd_byte, e);
    end
  endtask

  task automatic t_wrap_R2;
    logic [15:0] b;
    int d;
    pulse_snap('0); b = base_q;
    d = 2 * (16'hFFFF - b);
    repeat (d - 2) @(negedge clk);
    pulse_snap('0);
    chk("R2 reach max", base_q, 16'hFFFF);
    pulse_snap('0);
    chk("R2 wrap to zero", base_q, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) exp_held[i] = '0;
    repeat (3) @(negedge clk);
    t_reset_R8;
    rst_n = 1'b1;
    repeat (7) @(negedge clk);
    t_rate_R1(5);
    t_rate_R1(13);
    for (int a = 0; a < NA; a++) begin
      repeat (3 + 2*a) @(negedge clk);
      t_axis_R3_R6(a);
    end
    t_hold_R5;
    t_bytes_R7;
    t_all_R4;
    t_bytes_R7;
    t_wrap_R2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule